// File: doc/BRIEF.md
# Reciprocal Frequency Counter

This block measures the frequency of a slow or fast digital signal by the reciprocal method. It uses two counters that share one measurement window. The reference counter counts clock cycles. The input counter counts rising edges of the measured signal. The window opens and closes on falling edges of that signal, so it always spans a whole number of input periods. The accuracy therefore does not drop at low input frequencies the way it does with a fixed-time gate.

Software starts a measurement with a single-cycle `arm` pulse. The pulse clears the window state and both counters. The window opens at the first synchronised falling edge after arming. It stays open until the reference counter has wrapped once, then closes at the next falling edge. At that point both counts are frozen into capture registers and `done` is raised. The true reference count is 2^REF_W plus the captured value, and `refOvf` records that the wrap happened. Software performs the division elsewhere. If the input counter wraps inside the window, `tooFast` tells software that the result cannot be trusted.

Top module: `freq_reciprocal_counter`

## Requirements
- R1: After reset, done, refOvf and tooFast are 0, and refCount and inCount are 0.
- R2: An arm pulse clears done, refOvf, tooFast, refCount and inCount by the next cycle. It also aborts any measurement in progress, which then restarts from the armed state.
- R3: After arming, nothing is measured until a falling edge of sigIn (after the synchroniser) is seen. With sigIn held constant, done never rises.
- R4: The window opens at the first falling edge after arming. It stays open through the first wrap of the reference counter, and a falling edge in the same cycle as that wrap does not close it. It closes at the first falling edge after the wrap. refOvf is then 1, and refCount equals the window length in clock cycles minus 2^REF_W.
- R5: inCount equals the number of rising edges of sigIn inside the window, modulo 2^IN_W. For a periodic input this is the number of whole periods in the window.
- R6: If the input counter wraps inside the window, tooFast becomes 1 and stays 1 until the next arm pulse.
- R7: Once done is 1, done, refCount and inCount hold their values whatever sigIn does, until the next arm pulse.
- R8: done is never 1 while refOvf is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all logic runs on it |
| rstN | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | One-cycle pulse that clears and starts a measurement |
| sigIn | input | 1 | Signal to be measured, asynchronous |
| done | output | 1 | Captured counts are valid |
| refOvf | output | 1 | Sticky: reference counter wrapped during the window |
| tooFast | output | 1 | Sticky: input counter wrapped during the window |
| refCount | output | REF_W | Captured reference count, low REF_W bits |
| inCount | output | IN_W | Captured count of input rising edges |

## Verification
The assertions assume that `arm` is a single-cycle pulse and that `sigIn` changes no faster than every other clock. Under these conditions every falling edge reaches the gate logic as a one-cycle event, and the sticky flags change only as the properties expect. The stimulus drives `sigIn` as a square wave with a period of at least four clocks, changes it only on falling clock edges, and raises `arm` for exactly one cycle. The bench narrows both counters through parameters so that reference wraps and input wraps both happen within a short run.

// File: rtl/freq_pkg.sv
package freq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_RUN_PRE,
    ST_RUN_POST,
    ST_DONE
  } gateState_t;

  typedef struct packed {
    logic clear;
    logic run;
    logic capture;
  } dpCtrl_t;
endpackage

// File: rtl/freq_edge_sync.sv
module freq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sigIn,
  output logic riseEv,
  output logic fallEv
);
  localparam int LAST = STAGES;
  logic [LAST:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[LAST-1:0], sigIn};
  end

  assign riseEv = pipe[LAST-1] & ~pipe[LAST];
  assign fallEv = ~pipe[LAST-1] & pipe[LAST];
endmodule

// File: rtl/freq_datapath.sv
module freq_datapath
  import freq_pkg::*;
#(
  parameter int REF_W = 24,
  parameter int IN_W  = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctl,
  input  logic             riseEv,
  output logic             refWrap,
  output logic             inWrap,
  output logic [REF_W-1:0] refCap,
  output logic [IN_W-1:0]  inCap
);
  logic [REF_W-1:0] refCnt, refNext;
  logic [IN_W-1:0]  inCnt, inNext;

  assign refNext = refCnt + 1'b1;
  assign inNext  = inCnt + {{(IN_W-1){1'b0}}, riseEv};
  assign refWrap = ctl.run & (&refCnt);
  assign inWrap  = ctl.run & riseEv & (&inCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt <= '0;
      inCnt  <= '0;
      refCap <= '0;
      inCap  <= '0;
    end else if (ctl.clear) begin
      refCnt <= '0;
      inCnt  <= '0;
      refCap <= '0;
      inCap  <= '0;
    end else begin
      if (ctl.run) begin
        refCnt <= refNext;
        inCnt  <= inNext;
      end
      if (ctl.capture) begin
        refCap <= refNext;
        inCap  <= inNext;
      end
    end
  end
endmodule

// File: rtl/freq_ctrl.sv
module freq_ctrl
  import freq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    arm,
  input  logic    fallEv,
  input  logic    refWrap,
  input  logic    inWrap,
  output dpCtrl_t ctl,
  output logic    done,
  output logic    refOvf,
  output logic    tooFast
);
  gateState_t state;
  logic running;

  assign running     = (state == ST_RUN_PRE) || (state == ST_RUN_POST);
  assign ctl.clear   = arm;
  assign ctl.run     = !arm && running;
  assign ctl.capture = !arm && (state == ST_RUN_POST) && fallEv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      done    <= 1'b0;
      refOvf  <= 1'b0;
      tooFast <= 1'b0;
    end else if (arm) begin
      state   <= ST_ARMED;
      done    <= 1'b0;
      refOvf  <= 1'b0;
      tooFast <= 1'b0;
    end else begin
      if (inWrap) tooFast <= 1'b1;
      unique case (state)
        ST_ARMED:    if (fallEv) state <= ST_RUN_PRE;
        ST_RUN_PRE:  if (refWrap) begin
                       state  <= ST_RUN_POST;
                       refOvf <= 1'b1;
                     end
        ST_RUN_POST: if (fallEv) begin
                       state <= ST_DONE;
                       done  <= 1'b1;
                     end
        default:     state <= state;
      endcase
    end
  end
endmodule

// File: rtl/freq_reciprocal_counter.sv
module freq_reciprocal_counter
  import freq_pkg::*;
#(
  parameter int REF_W       = 24,
  parameter int IN_W        = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             arm,
  input  logic             sigIn,
  output logic             done,
  output logic             refOvf,
  output logic             tooFast,
  output logic [REF_W-1:0] refCount,
  output logic [IN_W-1:0]  inCount
);
  dpCtrl_t ctl;
  logic riseEv, fallEv, refWrap, inWrap;

  freq_edge_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .riseEv(riseEv), .fallEv(fallEv)
  );

  freq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .arm(arm), .fallEv(fallEv), .refWrap(refWrap),
    .inWrap(inWrap), .ctl(ctl), .done(done), .refOvf(refOvf), .tooFast(tooFast)
  );

  freq_datapath #(.REF_W(REF_W), .IN_W(IN_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .riseEv(riseEv), .refWrap(refWrap),
    .inWrap(inWrap), .refCap(refCount), .inCap(inCount)
  );
endmodule

// File: rtl/freq_checker.sv
module freq_checker #(
  parameter int REF_W = 24,
  parameter int IN_W  = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             arm,
  input logic             done,
  input logic             refOvf,
  input logic             tooFast,
  input logic [REF_W-1:0] refCount,
  input logic [IN_W-1:0]  inCount
);
  assert_arm_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    arm |=> (!done && !refOvf && !tooFast && refCount == '0 && inCount == '0));

  assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && !arm) |=> (done && $stable(refCount) && $stable(inCount)));

  assert_done_needs_wrap_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> refOvf);

  assert_fast_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (tooFast && !arm) |=> tooFast);

  assert_wrap_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (refOvf && !arm) |=> refOvf);
endmodule

bind freq_reciprocal_counter freq_checker #(.REF_W(REF_W), .IN_W(IN_W)) uChk (
  .clk(clk), .rstN(rstN), .arm(arm), .done(done), .refOvf(refOvf),
  .tooFast(tooFast), .refCount(refCount), .inCount(inCount)
);

// File: tb/sim_freq_reciprocal_counter.sv
module sim_freq_reciprocal_counter;
  localparam int REF_W = 8;
  localparam int IN_W  = 5;
  localparam int NVEC  = 8;
  // period, expected refCount, expected inCount, expected tooFast
  localparam int VEC [NVEC][4] = '{
    '{10, 4, 26, 0},
    '{37, 3, 7, 0},
    '{64, 64, 5, 0},
    '{100, 44, 3, 0},
    '{257, 1, 1, 0},
    '{9, 5, 29, 0},
    '{4, 4, 1, 1},
    '{8, 8, 1, 1}
  };

  logic clk = 0, rstN = 0, arm = 0, sigIn = 1;
  logic done, refOvf, tooFast;
  logic [REF_W-1:0] refCount;
  logic [IN_W-1:0] inCount;
  int checks = 0, failures = 0;
  int per = 10;
  bit hold = 0;

  always #2 clk = ~clk;

  freq_reciprocal_counter #(.REF_W(REF_W), .IN_W(IN_W)) u0 (
    .clk(clk), .rstN(rstN), .arm(arm), .sigIn(sigIn), .done(done),
    .refOvf(refOvf), .tooFast(tooFast), .refCount(refCount), .inCount(inCount)
  );

  initial begin
    forever begin
      if (hold) begin
        sigIn = 1;
        @(negedge clk);
      end else begin
        sigIn = 1;
        repeat (per / 2) @(negedge clk);
        sigIn = 0;
        repeat (per - per / 2) @(negedge clk);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulseArm();
    @(negedge clk); arm = 1;
    @(negedge clk); arm = 0;
  endtask

  task automatic waitDone(input string req);
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk); n++;
    end
    check({req, " done"}, int'(done), 1);
  endtask

  task automatic runVec(input int p, input int eRef, input int eIn, input int eFast);
    per = p;
    repeat (2 * p + 10) @(negedge clk);
    pulseArm();
    waitDone("R4");
    check("R4 refOvf", int'(refOvf), 1);
    check("R4 refCount", int'(refCount), eRef);
    check("R5 inCount", int'(inCount), eIn);
    check("R6 tooFast", int'(tooFast), eFast);
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 done", int'(done), 0);
    check("R1 refOvf", int'(refOvf), 0);
    check("R1 tooFast", int'(tooFast), 0);
    check("R1 refCount", int'(refCount), 0);
    check("R1 inCount", int'(inCount), 0);
    rstN = 1;

    for (int i = 0; i < NVEC; i++) begin
      runVec(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);
    end

    // R7: results frozen while input keeps toggling
    begin
      logic [REF_W-1:0] r0;
      logic [IN_W-1:0] i0;
      r0 = refCount; i0 = inCount;
      repeat (700) @(negedge clk);
      check("R7 done", int'(done), 1);
      check("R7 refCount", int'(refCount), int'(r0));
      check("R7 inCount", int'(inCount), int'(i0));
      check("R7 tooFast", int'(tooFast), 1);
    end

    // R2: arm clears results and flags
    pulseArm();
    check("R2 done", int'(done), 0);
    check("R2 tooFast", int'(tooFast), 0);
    check("R2 refCount", int'(refCount), 0);

    // R2: abort in the middle of a measurement
    per = 10;
    repeat (40) @(negedge clk);
    pulseArm();
    repeat (300) @(negedge clk);
    check("R2 refOvf mid", int'(refOvf), 1);
    pulseArm();
    check("R2 refOvf abort", int'(refOvf), 0);
    check("R2 done abort", int'(done), 0);
    waitDone("R2");
    check("R2 refCount", int'(refCount), 4);
    check("R2 inCount", int'(inCount), 26);

    // R3: no falling edge, no measurement
    hold = 1;
    repeat (50) @(negedge clk);
    pulseArm();
    repeat (600) @(negedge clk);
    check("R3 done", int'(done), 0);
    check("R3 refOvf", int'(refOvf), 0);
    per = 37;
    hold = 0;
    waitDone("R3");
    check("R3 refCount", int'(refCount), 3);
    check("R3 inCount", int'(inCount), 7);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule